// File: doc/BRIEF.md
# Display Memory Address Sequencer and Bus Arbiter

This block is the horizontal control sequencer for a two-trace digital storage display. It decides the source of every memory address. During the acquisition phase it takes the tracked sweep coordinate, and each SYNC pulse then starts a write at that coordinate. During the display phase a display counter counts SYNC pulses, and each pulse starts a read at the next horizontal position. The sequencer also decides which of the two traces a read belongs to. It reports that choice to the vertical logic on the trace-select output.

An external agent can borrow the memory bus by raising a request line. The sequencer answers only between memory accesses. Its answer is a one-cycle pull-low pulse that marks the start of the borrowed cycle. For exactly eight clocks after that, the address output enable is withdrawn, which models outputs that float. The read address is built from the display counter shifted up by one, with the trace select in bit 0, so the A and B traces interleave in memory.

Top module: `disp_addr_seq`

## Requirements
- R1: After reset, addr_o is 0, addr_oe_o is 1, wr_o is 0, req_low_o is 0 and trace_b_o is 0.
- R2: A SYNC pulse sampled while idle with acq_i=1 loads coord_i into addr_o on the next cycle. wr_o is 1 for exactly ACC_LEN (2) cycles, and addr_o holds until the next access starts.
- R3: A SYNC pulse sampled while idle with acq_i=0 starts a read. wr_o stays 0 and addr_o = {display count, trace select}, with the count in bits 9:1. After reset the reads run 0x000, 0x002, 0x004, and so on.
- R4: trace_b_o always equals addr_o bit 0. Reading at display count 511 advances the count to 0 and inverts the trace select, so a read at 0x3FE is followed by reads at 0x001 and then 0x003.
- R5: A SYNC pulse that arrives during an access or during a bus-grant window is ignored. It starts no access and does not advance the display count.
- R6: A bus request sampled while idle, with no SYNC in the same cycle, produces one cycle of req_low_o=1 on the next cycle. addr_oe_o is 0 for exactly 8 cycles, starting in that same cycle.
- R7: A bus request is never granted during an access. When SYNC and a request are sampled in the same idle cycle, the access wins. The grant follows one idle cycle after the access ends, and wr_o=1 only while addr_oe_o=1.
- R8: Requests during a grant window are ignored. A request still high when the window ends is granted again after one cycle with addr_oe_o=1.
- R9: The display count advances only on reads. Writes in the acquisition phase leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | SYNC strobe, one pulse per horizontal step |
| acq_i | input | 1 | Phase: 1 = acquisition (write), 0 = display (read) |
| coord_i | input | 10 | Tracked sweep coordinate from the acquisition loop |
| bus_req_i | input | 1 | External bus request, active high |
| addr_o | output | 10 | Memory address |
| addr_oe_o | output | 1 | Address output enable, 0 while the bus is lent |
| wr_o | output | 1 | 1 = write cycle, 0 = read or idle |
| trace_b_o | output | 1 | Trace select for the vertical logic, 1 = B |
| req_low_o | output | 1 | One-cycle pull-low of the request line, marks the grant |

## Verification
The address path is driven through a table that mixes writes of extreme, alternating and odd coordinates with display reads placed between them. A wrong select shows up as a coordinate appearing on a read, and a count that leaks into writes shows up as a skipped read address. Directed sequences then present SYNC during an access and during a grant window. They also present SYNC and a request in the same cycle, and hold a request high across a whole window. Together these separate ignoring a pulse from queueing it, and separate access priority from grant priority. A long run of reads walks the display count through its wrap, which confirms that the trace select inverts at the right read and lands in bit 0.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_GNT  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/disp_ctr.sv
module disp_ctr #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [DW-1:0] cnt_o,
    output logic          trace_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          trace;
    } ctr_t;

    ctr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (step_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (&r_q.cnt) begin
                r_d.trace = ~r_q.trace;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o   = r_q.cnt;
    assign trace_o = r_q.trace;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (cnt_o == DW'($past(cnt_o) + 1'b1)));          // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_o) && $stable(trace_o));          // R9
    AST_TRACE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (&cnt_o)) |=> (trace_o != $past(trace_o)));    // R4

endmodule

// File: rtl/addr_mux.sv
module addr_mux #(
    parameter int DW = 9,
    localparam int AW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          sel_coord_i,
    input  logic [AW-1:0] coord_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          trace_i,
    output logic [AW-1:0] addr_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } mux_t;

    mux_t r_d, r_q;
    logic [AW-1:0] pick;

    always_comb begin
        pick = sel_coord_i ? coord_i : {cnt_i, trace_i};
        r_d  = r_q;
        if (load_i) begin
            r_d.addr = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o = r_q.addr;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o));                             // R2
    AST_DISP_TRACE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !sel_coord_i) |=> (addr_o[0] == $past(trace_i))); // R4
    AST_WR_COORD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel_coord_i) |=> (addr_o == $past(coord_i)));  // R2

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import disp_pkg::*;
#(
    parameter int ACC_LEN = 2,
    parameter int HOLD    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic acq_i,
    input  logic req_i,
    output logic load_o,
    output logic step_o,
    output logic wr_o,
    output logic oe_o,
    output logic req_low_o
);

    localparam int TMAX = (HOLD > ACC_LEN) ? HOLD : ACC_LEN;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [TW-1:0] tmr;
        logic          wr;
        logic          pulse;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        load_o    = 1'b0;
        step_o    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (sync_i) begin
                    r_d.st  = ST_ACC;
                    r_d.tmr = TW'(ACC_LEN - 1);
                    r_d.wr  = acq_i;
                    load_o  = 1'b1;
                    step_o  = ~acq_i;
                end else if (req_i) begin
                    r_d.st    = ST_GNT;
                    r_d.tmr   = TW'(HOLD - 1);
                    r_d.pulse = 1'b1;
                end
            end
            ST_ACC: begin
                if (r_q.tmr == '0) begin
                    r_d.st = ST_IDLE;
                    r_d.wr = 1'b0;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_GNT: begin
                if (r_q.tmr == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
                r_d.wr = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.tmr   <= '0;
            r_q.wr    <= 1'b0;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_o      = r_q.wr;
    assign oe_o      = (r_q.st != ST_GNT);
    assign req_low_o = r_q.pulse;

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_low_o |=> !req_low_o);                                // R6
    AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_low_o |-> !$past(wr_o));                              // R7
    AST_NO_ACCESS_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !load_o);                                       // R5

endmodule

// File: rtl/disp_addr_seq.sv
module disp_addr_seq #(
    parameter int DW      = 9,
    parameter int ACC_LEN = 2,
    parameter int HOLD    = 8,
    localparam int AW     = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          acq_i,
    input  logic [AW-1:0] coord_i,
    input  logic          bus_req_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe_o,
    output logic          wr_o,
    output logic          trace_b_o,
    output logic          req_low_o
);

    logic          load;
    logic          step;
    logic [DW-1:0] cnt;
    logic          trace;

    seq_fsm #(
        .ACC_LEN (ACC_LEN),
        .HOLD    (HOLD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .acq_i     (acq_i),
        .req_i     (bus_req_i),
        .load_o    (load),
        .step_o    (step),
        .wr_o      (wr_o),
        .oe_o      (addr_oe_o),
        .req_low_o (req_low_o)
    );

    disp_ctr #(
        .DW (DW)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .cnt_o   (cnt),
        .trace_o (trace)
    );

    addr_mux #(
        .DW (DW)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .sel_coord_i (acq_i),
        .coord_i     (coord_i),
        .cnt_i       (cnt),
        .trace_i     (trace),
        .addr_o      (addr_o)
    );

    assign trace_b_o = addr_o[0];

    // Window-length checker: counts consecutive cycles with the enable withdrawn
    localparam int LW = $clog2(HOLD + 1);
    logic [LW-1:0] float_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            float_cnt_q <= '0;
        end else if (addr_oe_o) begin
            float_cnt_q <= '0;
        end else if (float_cnt_q != LW'(HOLD)) begin
            float_cnt_q <= float_cnt_q + 1'b1;
        end
    end

    AST_FLOAT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe_o |-> (float_cnt_q < LW'(HOLD)));                // R6
    AST_FLOAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe_o) |-> (float_cnt_q == LW'(HOLD)));         // R6
    AST_GRANT_STARTS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_low_o |-> !addr_oe_o);                                // R6
    AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> addr_oe_o);                                      // R7
    AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && $past(wr_o)) |-> $stable(addr_o));               // R2

endmodule

// File: tb/tb_disp_addr_seq.sv
module tb_disp_addr_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic       acq_i = 1'b0;
    logic [9:0] coord_i = '0;
    logic       bus_req_i = 1'b0;
    logic [9:0] addr_o;
    logic       addr_oe_o, wr_o, trace_b_o, req_low_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    disp_addr_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .acq_i     (acq_i),
        .coord_i   (coord_i),
        .bus_req_i (bus_req_i),
        .addr_o    (addr_o),
        .addr_oe_o (addr_oe_o),
        .wr_o      (wr_o),
        .trace_b_o (trace_b_o),
        .req_low_o (req_low_o)
    );

    // {acq, coord, expected addr, expected write}
    localparam logic [21:0] VEC [0:7] = '{
        {1'b1, 10'h155, 10'h155, 1'b1},
        {1'b0, 10'h3FF, 10'h000, 1'b0},
        {1'b1, 10'h3FF, 10'h3FF, 1'b1},
        {1'b0, 10'h155, 10'h002, 1'b0},
        {1'b0, 10'h000, 10'h004, 1'b0},
        {1'b1, 10'h2AA, 10'h2AA, 1'b1},
        {1'b0, 10'h2AA, 10'h006, 1'b0},
        {1'b1, 10'h001, 10'h001, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic acq, input logic [9:0] crd,
                          input logic [9:0] exp_addr, input logic exp_wr,
                          input bit do_chk, input string tag);
        @(negedge clk);
        sync_i  = 1'b1;
        acq_i   = acq;
        coord_i = crd;
        @(negedge clk);
        sync_i = 1'b0;
        if (do_chk) begin
            check({tag, " addr"}, addr_o, exp_addr);
            check({tag, " wr first"}, wr_o, exp_wr);
            check("R4 trace bit", trace_b_o, exp_addr[0]);
        end
        @(negedge clk);
        if (do_chk) check({tag, " wr second"}, wr_o, exp_wr);
        @(negedge clk);
        if (do_chk) begin
            check({tag, " wr ends"}, wr_o, 0);
            check({tag, " addr held"}, addr_o, exp_addr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 addr", addr_o, 0);
        check("R1 oe", addr_oe_o, 1);
        check("R1 wr", wr_o, 0);
        check("R1 req_low", req_low_o, 0);
        check("R1 trace", trace_b_o, 0);

        // Table: writes and reads interleaved (R2, R3, R9)
        for (int i = 0; i < 8; i++) begin
            access(VEC[i][21], VEC[i][20:11], VEC[i][10:1], VEC[i][0], 1'b1,
                   VEC[i][21] ? "R2 write" : "R3/R9 read");
        end

        // R5: SYNC during an access is ignored
        @(negedge clk);
        sync_i = 1'b1; acq_i = 1'b0;
        @(negedge clk);
        check("R5 first read addr", addr_o, 10'h008);
        @(negedge clk);
        sync_i = 1'b0;
        check("R5 addr unchanged", addr_o, 10'h008);
        repeat (2) @(negedge clk);
        access(1'b0, 10'h0, 10'h00A, 1'b0, 1'b1, "R5 next read");

        // R6: grant, with a SYNC inside the window (R5)
        @(negedge clk);
        bus_req_i = 1'b1;
        @(negedge clk);
        bus_req_i = 1'b0;
        check("R6 req_low pulse", req_low_o, 1);
        check("R6 oe low", addr_oe_o, 0);
        for (int k = 2; k <= 8; k++) begin
            if (k == 3) sync_i = 1'b1;
            @(negedge clk);
            sync_i = 1'b0;
            check("R6 oe low in window", addr_oe_o, 0);
            check("R6 req_low single", req_low_o, 0);
        end
        @(negedge clk);
        check("R6 oe back after 8", addr_oe_o, 1);
        access(1'b0, 10'h0, 10'h00C, 1'b0, 1'b1, "R5 no count in window");

        // R7: SYNC and request together, access wins; R8: held request
        @(negedge clk);
        sync_i = 1'b1; bus_req_i = 1'b1; acq_i = 1'b0;
        @(negedge clk);
        sync_i = 1'b0;
        check("R7 access wins addr", addr_o, 10'h00E);
        check("R7 no grant in access", req_low_o, 0);
        check("R7 oe during access", addr_oe_o, 1);
        @(negedge clk);
        check("R7 still no grant", req_low_o, 0);
        @(negedge clk);
        check("R7 idle gap", req_low_o, 0);
        check("R7 idle gap oe", addr_oe_o, 1);
        @(negedge clk);
        check("R7 grant after access", req_low_o, 1);
        check("R7 oe low", addr_oe_o, 0);
        for (int k = 2; k <= 8; k++) begin
            @(negedge clk);
            check("R8 held request ignored", req_low_o, 0);
            check("R8 oe low", addr_oe_o, 0);
        end
        @(negedge clk);
        check("R8 gap oe", addr_oe_o, 1);
        check("R8 gap no pulse", req_low_o, 0);
        @(negedge clk);
        check("R8 regrant", req_low_o, 1);
        bus_req_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 window over", addr_oe_o, 1);

        // R4: walk the display count to its wrap
        for (int k = 8; k < 511; k++) begin
            access(1'b0, 10'h0, 10'h0, 1'b0, 1'b0, "fill");
        end
        access(1'b0, 10'h0, 10'h3FE, 1'b0, 1'b1, "R4 last of trace A");
        access(1'b0, 10'h0, 10'h001, 1'b0, 1'b1, "R4 wrap to trace B");
        check("R4 trace B", trace_b_o, 1);
        access(1'b0, 10'h0, 10'h003, 1'b0, 1'b1, "R4 after wrap");
        // R9: a write after the wrap leaves the count alone
        access(1'b1, 10'h200, 10'h200, 1'b1, 1'b1, "R9 write");
        access(1'b0, 10'h0, 10'h005, 1'b0, 1'b1, "R9 count kept");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule